// File: doc/BRIEF.md
# Bus Transaction Timing Monitor

This block watches the active-low handshake lines of a shared parallel bus: the transaction-start strobe (`frame_n`), the initiator-ready line (`irdy_n`), the target-ready line (`trdy_n`) and the claim line (`devsel_n`). It never drives the bus. For each transaction it measures how many clocks the target took to claim it and reports that as a claim-speed code. It raises a one-cycle master-abort pulse when nobody claims in time. It also keeps sticky flags for wait-state limit breaches by either side and for a target that signals ready before it has claimed.

All inputs are sampled on the rising clock edge. The edge on which `frame_n` is first seen low after being high is "edge k". "n clocks after" means the edge k+n. A data phase completes on an edge where `irdy_n` and `trdy_n` are both low. The transaction ends on an edge where `frame_n` and `irdy_n` are both high.

The claim tracker is a four-state machine:
- IDLE goes to DECODE on a transaction start.
- DECODE goes to CLAIMED when `devsel_n` is seen low, to ABORTED when the claim window runs out, and back to IDLE if the bus goes idle.
- CLAIMED and ABORTED return to IDLE when the transaction ends.

Each wait timer is a three-state machine:
- OFF goes to FIRST when the transaction starts.
- OFF, FIRST or LATER goes to LATER on a later-phase re-arm.
- FIRST and LATER return to OFF on a ready strobe, on a limit breach, or when the tracker halts the timer.

Top module: `bus_timing_monitor`

## Requirements
- R1: After reset, `claim_code` is 0, `master_abort` is 0 and all three violation flags are 0.
- R2: If `devsel_n` is first seen low at edge k+1, k+2 or k+3, `claim_code` becomes 1 (fast), 2 (medium) or 3 (slow) right after that edge. Before that edge it stays 0.
- R3: If `devsel_n` is first seen low at edge k+4, `claim_code` becomes 4 (subtractive) right after that edge.
- R4: If `devsel_n` is still high at edge k+5, `master_abort` is 1 for exactly the one cycle after that edge, and `claim_code` stays 0. Before that edge `master_abort` stays 0.
- R5: `claim_code` keeps its value until the next transaction start, and becomes 0 right after edge k of that next transaction.
- R6: If `trdy_n` is seen low while `devsel_n` is high during a transaction, `viol_order` is set.
- R7: If `irdy_n` is still high at edge k+8, `viol_init_wait` is set. If `irdy_n` is low by edge k+8, it is not set.
- R8: During a transaction, let edge r be an edge where `irdy_n` rises while `frame_n` is low. If `irdy_n` is still high at edge r+8, `viol_init_wait` is set. If it is low again by then, it is not set.
- R9: If `trdy_n` is still high at edge k+16, `viol_tgt_wait` is set. If `trdy_n` is low by edge k+16, it is not set.
- R10: Let edge j be an edge where a data phase completes with `frame_n` low. If `trdy_n` is high on every edge from j+1 through j+8, `viol_tgt_wait` is set. If it is low on one of those edges, it is not set.
- R11: Violation flags stay set until `clear_flags` is seen high. If a violation and `clear_flags` occur on the same edge, the flag ends up set.
- R12: After a master abort, no wait-state flag is raised for that transaction, however long the initiator holds the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| clear_flags | input | 1 | Clears the sticky violation flags |
| claim_code | output | 3 | 0 none, 1 fast, 2 medium, 3 slow, 4 subtractive |
| master_abort | output | 1 | One-cycle pulse when the claim window expires |
| viol_order | output | 1 | Sticky: target ready seen before claim |
| viol_init_wait | output | 1 | Sticky: initiator wait limit exceeded |
| viol_tgt_wait | output | 1 | Sticky: target wait limit exceeded |

## Verification
The bench builds the block with its default parameters:
- four claim slots;
- an initiator limit of 8 for both the first and the later phases;
- a target limit of 16 for the first phase and 8 for later phases.

With these values every boundary is reachable within a few dozen clocks: each claim bin, the fifth-clock abort, and each wait limit hit exactly versus missed by one clock. Each limit is driven once to its last legal clock and once a clock past it. The abort case also holds the bus for well past both wait limits, to show the timers stay halted.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

    // Claim tracker states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DECODE  = 2'd1,
        ST_CLAIMED = 2'd2,
        ST_ABORTED = 2'd3
    } mon_state_e;

    // Claim speed bins reported at the port
    typedef enum logic [2:0] {
        CLM_NONE   = 3'd0,
        CLM_FAST   = 3'd1,
        CLM_MEDIUM = 3'd2,
        CLM_SLOW   = 3'd3,
        CLM_SUBTR  = 3'd4
    } claim_e;

    // Wait timer states: the state selects the active limit
    typedef enum logic [1:0] {
        TM_OFF   = 2'd0,
        TM_FIRST = 2'd1,
        TM_LATER = 2'd2
    } timer_state_e;

    // Sticky flag positions
    localparam int FLAG_ORDER = 0;
    localparam int FLAG_INIT  = 1;
    localparam int FLAG_TGT   = 2;
    localparam int NUM_FLAGS  = 3;

endpackage

// File: rtl/claim_tracker.sv
module claim_tracker
    import bus_mon_pkg::*;
#(
    parameter int CLAIM_SLOTS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       trdy_n,
    input  logic       devsel_n,
    output logic [2:0] claim_code,
    output logic       master_abort,
    output logic       txn_start,
    output logic       init_rearm,
    output logic       tgt_rearm,
    output logic       timer_halt,
    output logic       order_err
);

    localparam int ABORT_SLOT = CLAIM_SLOTS + 1;
    localparam int DW         = $clog2(ABORT_SLOT + 1);

    mon_state_e      state_q, state_d;
    claim_e          claim_q;
    logic [DW-1:0]   dcnt_q;
    logic [DW-1:0]   dnext;
    logic            frame_q;
    logic            irdy_q;
    logic            bus_idle;
    logic            active;
    logic            claim_evt;
    logic            abort_evt;

    // Map the number of clocks to claim onto a speed bin
    function automatic claim_e bin_of(input logic [DW-1:0] n);
        if (n == DW'(CLAIM_SLOTS)) return CLM_SUBTR;
        else if (n == DW'(1))      return CLM_FAST;
        else if (n == DW'(2))      return CLM_MEDIUM;
        else                       return CLM_SLOW;
    endfunction

    assign dnext     = dcnt_q + DW'(1);
    assign bus_idle  = frame_n && irdy_n;
    assign active    = (state_q == ST_DECODE) || (state_q == ST_CLAIMED);
    assign txn_start = (state_q == ST_IDLE) && !frame_n && frame_q;
    assign claim_evt = (state_q == ST_DECODE) && !bus_idle && !devsel_n;
    assign abort_evt = (state_q == ST_DECODE) && !bus_idle && devsel_n
                       && (dnext == DW'(ABORT_SLOT));

    // Phase events handed to the wait timers
    assign init_rearm = active && !frame_n && irdy_n && !irdy_q;
    assign tgt_rearm  = active && !frame_n && !irdy_n && !trdy_n;
    assign timer_halt = !active || bus_idle || abort_evt;
    assign order_err  = active && !trdy_n && devsel_n;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (txn_start) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (bus_idle)       state_d = ST_IDLE;
                else if (claim_evt) state_d = ST_CLAIMED;
                else if (abort_evt) state_d = ST_ABORTED;
            end
            ST_CLAIMED: begin
                if (bus_idle) state_d = ST_IDLE;
            end
            ST_ABORTED: begin
                if (bus_idle) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_q      <= CLM_NONE;
            master_abort <= 1'b0;
            dcnt_q       <= '0;
            frame_q      <= 1'b1;
            irdy_q       <= 1'b1;
        end else begin
            frame_q      <= frame_n;
            irdy_q       <= irdy_n;
            master_abort <= abort_evt;
            if (txn_start) begin
                claim_q <= CLM_NONE;
                dcnt_q  <= '0;
            end else if (state_q == ST_DECODE) begin
                dcnt_q <= dnext;
                if (claim_evt) claim_q <= bin_of(dnext);
            end
        end
    end

    assign claim_code = claim_q;

    AST_ABORT_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |-> (claim_q == CLM_NONE)); // R4

    AST_ABORT_FROM_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |-> (state_q == ST_ABORTED || state_q == ST_IDLE)); // R4

    AST_CLAIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_start && state_q != ST_DECODE) |=> $stable(claim_q)); // R5

    AST_CLAIM_CLEARED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> (claim_q == CLM_NONE)); // R5

endmodule

// File: rtl/wait_timer.sv
module wait_timer
    import bus_mon_pkg::*;
#(
    parameter int FIRST_LIM = 8,
    parameter int LATER_LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_first,
    input  logic arm_later,
    input  logic halt,
    input  logic ready_n,
    output logic overrun
);

    localparam int MAXL = (FIRST_LIM > LATER_LIM) ? FIRST_LIM : LATER_LIM;
    localparam int CW   = $clog2(MAXL + 1);

    timer_state_e   st_q, st_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_inc;
    logic [CW-1:0]  lim;
    logic           armed;
    logic           any_arm;

    assign armed   = (st_q != TM_OFF);
    assign any_arm = arm_first || arm_later;
    assign cnt_inc = cnt_q + CW'(1);
    assign lim     = (st_q == TM_FIRST) ? CW'(FIRST_LIM) : CW'(LATER_LIM);
    assign overrun = armed && !any_arm && !halt && ready_n && (cnt_inc == lim);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (arm_first)      st_d = TM_FIRST;
        else if (arm_later) st_d = TM_LATER;
        else if (halt)      st_d = TM_OFF;
        else begin
            unique case (st_q)
                TM_OFF: st_d = TM_OFF;
                TM_FIRST, TM_LATER: begin
                    if (!ready_n || overrun) st_d = TM_OFF;
                end
                default: st_d = TM_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TM_OFF;
        else        st_q <= st_d;
    end

    // Wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (any_arm)            cnt_q <= '0;
        else if (armed && ready_n)   cnt_q <= cnt_inc;
    end

    AST_WAIT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt_q < lim)); // R7

    AST_ARM_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        any_arm |=> (cnt_q == '0 && armed)); // R8

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clear,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clear)  q[i] <= 1'b0;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clear) |=> q[i]); // R11

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]); // R11
    end

endmodule

// File: rtl/bus_timing_monitor.sv
module bus_timing_monitor
    import bus_mon_pkg::*;
#(
    parameter int CLAIM_SLOTS    = 4,
    parameter int INIT_FIRST_LIM = 8,
    parameter int INIT_LATER_LIM = 8,
    parameter int TGT_FIRST_LIM  = 16,
    parameter int TGT_LATER_LIM  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       trdy_n,
    input  logic       devsel_n,
    input  logic       clear_flags,
    output logic [2:0] claim_code,
    output logic       master_abort,
    output logic       viol_order,
    output logic       viol_init_wait,
    output logic       viol_tgt_wait
);

    logic                 txn_start;
    logic                 init_rearm;
    logic                 tgt_rearm;
    logic                 timer_halt;
    logic                 order_err;
    logic                 init_over;
    logic                 tgt_over;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    claim_tracker #(
        .CLAIM_SLOTS (CLAIM_SLOTS)
    ) u_claim (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .trdy_n       (trdy_n),
        .devsel_n     (devsel_n),
        .claim_code   (claim_code),
        .master_abort (master_abort),
        .txn_start    (txn_start),
        .init_rearm   (init_rearm),
        .tgt_rearm    (tgt_rearm),
        .timer_halt   (timer_halt),
        .order_err    (order_err)
    );

    // Initiator side: later phases measured from ready deassertion
    wait_timer #(
        .FIRST_LIM (INIT_FIRST_LIM),
        .LATER_LIM (INIT_LATER_LIM)
    ) u_init_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_first (txn_start),
        .arm_later (init_rearm),
        .halt      (timer_halt),
        .ready_n   (irdy_n),
        .overrun   (init_over)
    );

    // Target side: later phases measured from phase completion
    wait_timer #(
        .FIRST_LIM (TGT_FIRST_LIM),
        .LATER_LIM (TGT_LATER_LIM)
    ) u_tgt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_first (txn_start),
        .arm_later (tgt_rearm),
        .halt      (timer_halt),
        .ready_n   (trdy_n),
        .overrun   (tgt_over)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_ORDER] = order_err;
        flag_set[FLAG_INIT]  = init_over;
        flag_set[FLAG_TGT]   = tgt_over;
    end

    sticky_flags #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clear (clear_flags),
        .q     (flag_q)
    );

    assign viol_order     = flag_q[FLAG_ORDER];
    assign viol_init_wait = flag_q[FLAG_INIT];
    assign viol_tgt_wait  = flag_q[FLAG_TGT];

    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |=> !master_abort); // R4

    AST_ABORT_NO_WAIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        master_abort |-> (!init_over && !tgt_over)); // R12

endmodule

// File: tb/tb_bus_timing_monitor.sv
`timescale 1ns/1ps
module tb_bus_timing_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       irdy_n = 1'b1;
    logic       trdy_n = 1'b1;
    logic       devsel_n = 1'b1;
    logic       clr = 1'b0;
    logic [2:0] claim_code;
    logic       master_abort;
    logic       viol_order;
    logic       viol_init_wait;
    logic       viol_tgt_wait;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    bus_timing_monitor dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_n        (frame_n),
        .irdy_n         (irdy_n),
        .trdy_n         (trdy_n),
        .devsel_n       (devsel_n),
        .clear_flags    (clr),
        .claim_code     (claim_code),
        .master_abort   (master_abort),
        .viol_order     (viol_order),
        .viol_init_wait (viol_init_wait),
        .viol_tgt_wait  (viol_tgt_wait)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, return just after the next rising edge
    task automatic cyc(input logic f, input logic i, input logic t, input logic d);
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d;
        @(posedge clk);
        #1;
    endtask

    task automatic end_txn();
        cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 1);
    endtask

    task automatic clear_all();
        clr = 1'b1;
        cyc(1, 1, 1, 1);
        clr = 1'b0;
        check("R11 clear order", viol_order, 0);
        check("R11 clear init", viol_init_wait, 0);
        check("R11 clear tgt", viol_tgt_wait, 0);
    endtask

    task automatic t_reset();
        check("R1 code", claim_code, 0);
        check("R1 abort", master_abort, 0);
        check("R1 flags", {viol_order, viol_init_wait, viol_tgt_wait}, 0);
    endtask

    task automatic t_claim(input int n, input string tag);
        cyc(0, 1, 1, 1);
        check("R5 code cleared at start", claim_code, 0);
        for (int e = 1; e < n; e++) cyc(0, 1, 1, 1);
        check({tag, " not early"}, claim_code, 0);
        cyc(0, 0, 1, 0);
        check({tag, " bin"}, claim_code, n);
        end_txn();
        check({tag, " no flags"}, {viol_order, viol_init_wait, viol_tgt_wait}, 0);
    endtask

    task automatic t_hold();
        t_claim(1, "R2 fast");
        for (int e = 0; e < 5; e++) cyc(1, 1, 1, 1);
        check("R5 code held", claim_code, 1);
        cyc(0, 1, 1, 1);
        check("R5 code cleared", claim_code, 0);
        cyc(0, 0, 1, 0);
        end_txn();
    endtask

    task automatic t_abort();
        cyc(0, 1, 1, 1);
        for (int e = 1; e <= 4; e++) cyc(0, 1, 1, 1);
        check("R4 no abort at 4", master_abort, 0);
        cyc(0, 1, 1, 1);
        check("R4 abort pulse", master_abort, 1);
        check("R4 code none", claim_code, 0);
        cyc(0, 1, 1, 1);
        check("R4 pulse one cycle", master_abort, 0);
        for (int e = 0; e < 20; e++) cyc(0, 1, 1, 1);
        check("R12 init halted", viol_init_wait, 0);
        check("R12 tgt halted", viol_tgt_wait, 0);
        cyc(1, 1, 1, 1);
    endtask

    task automatic t_order();
        cyc(0, 1, 1, 1);
        clr = 1'b1;
        cyc(0, 1, 0, 1);
        clr = 1'b0;
        check("R6 early ready / R11 set wins", viol_order, 1);
        cyc(0, 0, 0, 0);
        end_txn();
        for (int e = 0; e < 3; e++) cyc(1, 1, 1, 1);
        check("R11 sticky", viol_order, 1);
        clear_all();
    endtask

    task automatic t_init_first(input int del);
        cyc(0, 1, 1, 1);
        for (int e = 1; e < del; e++) cyc(0, 1, 1, 0);
        check("R7 initiator first limit", viol_init_wait, (del > 8) ? 1 : 0);
        end_txn();
        check("R7 target untouched", viol_tgt_wait, 0);
        clear_all();
    endtask

    task automatic t_init_later(input int gap);
        cyc(0, 1, 1, 1);
        cyc(0, 0, 0, 0);
        for (int e = 0; e < gap; e++) cyc(0, 1, 0, 0);
        check("R8 initiator later limit", viol_init_wait, (gap > 8) ? 1 : 0);
        end_txn();
        check("R8 target untouched", viol_tgt_wait, 0);
        clear_all();
    endtask

    task automatic t_tgt_first(input int del);
        cyc(0, 1, 1, 1);
        for (int e = 1; e < del; e++) cyc(0, 0, 1, 0);
        check("R9 target first limit", viol_tgt_wait, (del > 16) ? 1 : 0);
        check("R9 initiator untouched", viol_init_wait, 0);
        end_txn();
        clear_all();
    endtask

    task automatic t_tgt_later(input int gap);
        cyc(0, 1, 1, 1);
        cyc(0, 0, 0, 0);
        for (int e = 1; e <= gap; e++) cyc(0, 0, 1, 0);
        check("R10 target later limit", viol_tgt_wait, (gap >= 8) ? 1 : 0);
        check("R10 initiator untouched", viol_init_wait, 0);
        end_txn();
        clear_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 1, 1);
        t_claim(1, "R2 fast");
        t_claim(2, "R2 medium");
        t_claim(3, "R2 slow");
        t_claim(4, "R3 subtractive");
        t_hold();
        t_abort();
        t_claim(2, "R2 after abort");
        t_order();
        t_init_first(8);
        t_init_first(9);
        t_init_later(8);
        t_init_later(9);
        t_tgt_first(16);
        t_tgt_first(17);
        t_tgt_later(7);
        t_tgt_later(8);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule